// File: doc/BRIEF.md
# Bootstrap Loader ROM Copier

This block moves a 64-word start-up program out of one of four loader ROM sockets and into the highest 64 words of main memory. An operator front-panel load button raises a single-cycle `start` strobe. On that strobe the block reads two fields of the 16-bit switch register: one names the ROM socket to copy from, and the other gives the select code of the interface card that the program will boot from. It also reads the memory-size input on the same strobe.

The copy then writes one word per clock in ascending address order, starting at the memory size minus 64. Two words are changed on the way through. The DMA configuration word, at ROM index 62, keeps its upper bits but takes the select code in its low six bits. The last word, at ROM index 63, is replaced by the two's-complement negative of the load address, which the loaded program uses to avoid overwriting itself. Execution of the copied program begins at ROM index 0 and is outside this block. If the chosen socket is marked as empty or not applicable, nothing is written and an error is flagged.

Top module: `boot_loader_copier`

## Requirements
- R1: After reset, `mem_we`, `done` and `error` are low and no memory write takes place until a `start` strobe.
- R2: Switch-register bits 15:14 select the socket: value k copies the words that arrive on `rom_data[16*k+15 : 16*k]`, and ROM words 0 to 61 are written unchanged.
- R3: Switch-register bits 11:6 hold the select code; the word written for ROM index 62 carries the ROM word's bits 15:6 and the select code in bits 5:0.
- R4: The word written for ROM index 63 is the 16-bit two's-complement negation of the load address (`mem_size` minus 64).
- R5: A copy makes exactly 64 writes on 64 consecutive clocks, the first to address `mem_size - 64` one clock after the `start` edge, each later one to the previous address plus one.
- R6: `done` is high for exactly one cycle, the cycle after the last write, with `error` low.
- R7: When the `socket_present` bit of the selected socket is 0, no write is made, and `done` and `error` are both high for exactly one cycle, the cycle after the `start` edge.
- R8: While a copy is running, `start`, `switch_reg`, `mem_size` and `socket_present` have no effect; the values captured at the `start` edge apply to the whole copy.
- R9: During each write, `rom_addr` equals the ROM index of the word being written, so it runs from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load strobe from the front-panel button |
| switch_reg | input | 16 | Switch register: socket in 15:14, select code in 11:6 |
| mem_size | input | 16 | Installed memory size in words (64 to 32768) |
| socket_present | input | 4 | One bit per socket, 1 when that socket holds a usable loader |
| rom_data | input | 64 | Read data of the four ROM sockets, socket k in bits 16k+15:16k, valid in the same cycle as `rom_addr` |
| rom_addr | output | 6 | Word index presented to all ROM sockets |
| mem_we | output | 1 | Memory write enable, one word per clock |
| mem_addr | output | 15 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| done | output | 1 | One-cycle pulse at the end of a copy or a rejected request |
| error | output | 1 | One-cycle pulse together with `done` when the socket is empty |

## Verification
The assertions rely on `mem_size` being at least 64 and no larger than the 15-bit address space, so that the load base never wraps. They also rely on ROM data being combinational in `rom_addr` within the same cycle. The stimulus draws memory sizes only from 64 to 32768 and generates ROM words in the bench as a pure function of socket, index and a per-run salt. Mid-copy disturbances (a second strobe, an inverted switch register, a new size and all sockets marked empty) stay in those ranges, so only the capture logic can catch them.

// File: rtl/boot_copy_pkg.sv
// Shared constants and types for the bootstrap loader copier.
// Assumes a 16-bit word and a 64-word loader image per socket.
package boot_copy_pkg;
    localparam int WORD_W    = 16;
    localparam int ROM_AW    = 6;
    localparam int ROM_WORDS = 1 << ROM_AW;
    localparam int SOCK_W    = 2;
    localparam int N_SOCK    = 1 << SOCK_W;
    localparam int SOCK_LSB  = 14;
    localparam int SC_W      = 6;
    localparam int SC_LSB    = 6;
    localparam int DMA_IDX   = ROM_WORDS - 2;
    localparam int FWA_IDX   = ROM_WORDS - 1;

    typedef enum logic {
        CP_IDLE = 1'b0,
        CP_COPY = 1'b1
    } copy_state_t;
endpackage

// File: rtl/boot_sw_decode.sv
// Splits the switch register into socket number and select code.
// Assumes the field positions fixed by the package; other bits are left
// for the loaded program and ignored here.
module boot_sw_decode #(
    parameter int WORD_W   = 16,
    parameter int SOCK_W   = 2,
    parameter int SOCK_LSB = 14,
    parameter int SC_W     = 6,
    parameter int SC_LSB   = 6
) (
    input  logic [WORD_W-1:0] sw,
    output logic [SOCK_W-1:0] sock,
    output logic [SC_W-1:0]   sc
);
    // Field extraction; bits outside both fields are gathered as unused.
    logic unused_user_bits;
    assign sock = sw[SOCK_LSB +: SOCK_W];
    assign sc   = sw[SC_LSB +: SC_W];
    assign unused_user_bits = ^sw;
endmodule

// File: rtl/boot_rom_mux.sv
// Chooses one socket's read data out of the flattened ROM data bus.
// Assumes every socket answers the shared address combinationally.
module boot_rom_mux #(
    parameter int WORD_W = 16,
    parameter int SOCK_W = 2,
    parameter int N_SOCK = 4
) (
    input  logic [N_SOCK*WORD_W-1:0] flat,
    input  logic [SOCK_W-1:0]        sel,
    output logic [WORD_W-1:0]        word
);
    logic [WORD_W-1:0] lanes [N_SOCK];

    // One lane per socket, unpacked from the flat bus.
    for (genvar g = 0; g < N_SOCK; g++) begin : g_lane
        assign lanes[g] = flat[g*WORD_W +: WORD_W];
    end

    // Lane selection by the captured socket number.
    assign word = lanes[sel];
endmodule

// File: rtl/boot_word_patch.sv
// Rewrites the two special loader words while they pass to memory:
// the DMA configuration word gets the select code in its low bits and
// the final word becomes the negated load address.
// Assumes base already fits in one word.
module boot_word_patch #(
    parameter int WORD_W  = 16,
    parameter int ROM_AW  = 6,
    parameter int SC_W    = 6,
    parameter int DMA_IDX = 62,
    parameter int FWA_IDX = 63
) (
    input  logic [ROM_AW-1:0] idx,
    input  logic [WORD_W-1:0] raw,
    input  logic [SC_W-1:0]   sc,
    input  logic [WORD_W-1:0] base,
    output logic [WORD_W-1:0] patched
);
    // Pick the replacement for the current index, else pass the ROM word.
    always_comb begin
        patched = raw;
        if (idx == ROM_AW'(DMA_IDX)) begin
            patched = {raw[WORD_W-1:SC_W], sc};
        end else if (idx == ROM_AW'(FWA_IDX)) begin
            patched = WORD_W'(0) - base;
        end
    end
endmodule

// File: rtl/boot_copy_seq.sv
// Copy sequencer: captures the request on start, walks the ROM index
// once per clock and reports completion or an empty socket.
// Assumes mem_size is at least ROM_WORDS; start is ignored while copying.
module boot_copy_seq
    import boot_copy_pkg::*;
#(
    parameter int MEM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SOCK_W-1:0] sock_in,
    input  logic [SC_W-1:0]   sc_in,
    input  logic [MEM_AW:0]   mem_size,
    input  logic [N_SOCK-1:0] present,
    output logic              busy,
    output logic [ROM_AW-1:0] idx,
    output logic [SOCK_W-1:0] sock_q,
    output logic [SC_W-1:0]   sc_q,
    output logic [MEM_AW-1:0] base_q,
    output logic              done,
    output logic              error
);
    localparam logic [ROM_AW-1:0] LAST_IDX = ROM_AW'(ROM_WORDS - 1);

    copy_state_t state;

    // Request capture, index stepping and end-of-copy pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CP_IDLE;
            idx    <= '0;
            sock_q <= '0;
            sc_q   <= '0;
            base_q <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                CP_IDLE: begin
                    if (start) begin
                        sock_q <= sock_in;
                        sc_q   <= sc_in;
                        base_q <= MEM_AW'(mem_size - (MEM_AW+1)'(ROM_WORDS));
                        idx    <= '0;
                        if (present[sock_in]) begin
                            state <= CP_COPY;
                        end else begin
                            done  <= 1'b1;
                            error <= 1'b1;
                        end
                    end
                end
                CP_COPY: begin
                    if (idx == LAST_IDX) begin
                        state <= CP_IDLE;
                        idx   <= '0;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= CP_IDLE;
            endcase
        end
    end

    // Busy flag seen by the write port.
    assign busy = (state == CP_COPY);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_empty_no_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !present[sock_in]) |=> (!busy && done && error));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && idx != LAST_IDX) |=> (busy && $stable(sock_q) && $stable(base_q)));
endmodule

// File: rtl/boot_loader_copier.sv
// Top of the bootstrap loader copier. Decodes the switch register,
// sequences 64 single-word writes to the top of memory and patches the
// DMA configuration and negative start-address words on the way.
// Assumes 64 <= mem_size <= 2**MEM_AW and MEM_AW <= WORD_W.
module boot_loader_copier
    import boot_copy_pkg::*;
#(
    parameter int MEM_AW = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [WORD_W-1:0]        switch_reg,
    input  logic [WORD_W-1:0]        mem_size,
    input  logic [N_SOCK-1:0]        socket_present,
    input  logic [N_SOCK*WORD_W-1:0] rom_data,
    output logic [ROM_AW-1:0]        rom_addr,
    output logic                     mem_we,
    output logic [MEM_AW-1:0]        mem_addr,
    output logic [WORD_W-1:0]        mem_wdata,
    output logic                     done,
    output logic                     error
);
    logic [SOCK_W-1:0] sw_sock;
    logic [SC_W-1:0]   sw_sc;
    logic              busy;
    logic [ROM_AW-1:0] idx;
    logic [SOCK_W-1:0] sock_q;
    logic [SC_W-1:0]   sc_q;
    logic [MEM_AW-1:0] base_q;
    logic [WORD_W-1:0] rom_word;
    logic [MEM_AW:0]   size_w;

    // Memory size resized to the sequencer's width.
    assign size_w = (MEM_AW+1)'(mem_size);

    boot_sw_decode #(
        .WORD_W(WORD_W), .SOCK_W(SOCK_W), .SOCK_LSB(SOCK_LSB),
        .SC_W(SC_W), .SC_LSB(SC_LSB)
    ) u_decode (
        .sw(switch_reg), .sock(sw_sock), .sc(sw_sc)
    );

    boot_copy_seq #(.MEM_AW(MEM_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sock_in(sw_sock), .sc_in(sw_sc), .mem_size(size_w),
        .present(socket_present), .busy(busy), .idx(idx),
        .sock_q(sock_q), .sc_q(sc_q), .base_q(base_q),
        .done(done), .error(error)
    );

    boot_rom_mux #(.WORD_W(WORD_W), .SOCK_W(SOCK_W), .N_SOCK(N_SOCK)) u_mux (
        .flat(rom_data), .sel(sock_q), .word(rom_word)
    );

    boot_word_patch #(
        .WORD_W(WORD_W), .ROM_AW(ROM_AW), .SC_W(SC_W),
        .DMA_IDX(DMA_IDX), .FWA_IDX(FWA_IDX)
    ) u_patch (
        .idx(idx), .raw(rom_word), .sc(sc_q),
        .base(WORD_W'(base_q)), .patched(mem_wdata)
    );

    // Write port: ROM index and memory address advance together.
    assign rom_addr = idx;
    assign mem_we   = busy;
    assign mem_addr = base_q + MEM_AW'(idx);

    assert_first_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> mem_addr == MEM_AW'($past(size_w) - (MEM_AW+1)'(ROM_WORDS)));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(rom_addr) != ROM_AW'(FWA_IDX))
            |-> mem_addr == $past(mem_addr) + 1'b1);

    assert_dma_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rom_addr == ROM_AW'(DMA_IDX))
            |-> mem_wdata[WORD_W-1:SC_W] == rom_word[WORD_W-1:SC_W]);

    assert_neg_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rom_addr == ROM_AW'(FWA_IDX))
            |-> (mem_wdata + WORD_W'(mem_addr - MEM_AW'(FWA_IDX))) == '0);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rom_addr == ROM_AW'(FWA_IDX)) |=> (done && !error && !mem_we));
endmodule

// File: tb/boot_loader_copier_test.sv
`timescale 1ns/1ps
module boot_loader_copier_test;
    localparam int MEM_AW = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] switch_reg;
    logic [15:0] mem_size;
    logic [3:0]  socket_present;
    logic [63:0] rom_data;
    logic [5:0]  rom_addr;
    logic        mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        done;
    logic        error;

    logic [15:0] salt;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    boot_loader_copier #(.MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .switch_reg(switch_reg),
        .mem_size(mem_size), .socket_present(socket_present),
        .rom_data(rom_data), .rom_addr(rom_addr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .error(error)
    );

    function automatic logic [15:0] rom_word(input int s, input logic [5:0] i,
                                             input logic [15:0] sl);
        logic [15:0] a;
        a = 16'((s + 1) * 40503) ^ 16'(int'(i) * 3079 + int'(i) * int'(i));
        return a ^ sl;
    endfunction

    // ROM model: every socket answers the shared address combinationally.
    always_comb begin
        for (int s = 0; s < 4; s++) rom_data[s*16 +: 16] = rom_word(s, rom_addr, salt);
    end

    function automatic logic [15:0] exp_word(input int s, input int k,
                                             input logic [5:0] sc, input logic [15:0] base,
                                             input logic [15:0] sl);
        logic [15:0] r;
        r = rom_word(s, 6'(k), sl);
        if (k == 62) return {r[15:6], sc};
        if (k == 63) return 16'(0) - base;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_copy(input logic [15:0] sw, input logic [15:0] size,
                            input logic [3:0] pres, input bit disturb);
        int s;
        logic [5:0]  sc;
        logic [15:0] base;
        logic [15:0] w;
        @(negedge clk);
        switch_reg = sw; mem_size = size; socket_present = pres; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = int'(sw[15:14]);
        sc = sw[11:6];
        base = size - 16'd64;
        if (!pres[s]) begin
            check(mem_we == 1'b0, "R7", "write on empty socket", 32'(mem_we), 0);
            check(done == 1'b1, "R7", "done on empty socket", 32'(done), 1);
            check(error == 1'b1, "R7", "error on empty socket", 32'(error), 1);
            @(negedge clk);
            check(done == 1'b0 && error == 1'b0, "R7", "pulse length",
                  32'({done, error}), 0);
            check(mem_we == 1'b0, "R7", "late write", 32'(mem_we), 0);
            return;
        end
        for (int k = 0; k < 64; k++) begin
            if (k > 0) @(negedge clk);
            w = exp_word(s, k, sc, base, salt);
            check(mem_we == 1'b1, "R5", "write enable", 32'(mem_we), 1);
            check(mem_addr == MEM_AW'(base + 16'(k)), "R5", "address",
                  32'(mem_addr), 32'(MEM_AW'(base + 16'(k))));
            check(rom_addr == 6'(k), "R9", "rom index", 32'(rom_addr), 32'(k));
            if (k == 62)
                check(mem_wdata == w, "R3", "dma word", 32'(mem_wdata), 32'(w));
            else if (k == 63)
                check(mem_wdata == w, "R4", "negative start", 32'(mem_wdata), 32'(w));
            else
                check(mem_wdata == w, "R2", "copied word", 32'(mem_wdata), 32'(w));
            check(done == 1'b0, "R6", "early done", 32'(done), 0);
            if (disturb && k == 10) begin
                start = 1'b1; switch_reg = ~sw; mem_size = 16'd4096; socket_present = 4'b0;
            end
            if (disturb && k == 11) start = 1'b0;
        end
        @(negedge clk);
        check(done == 1'b1 && error == 1'b0, "R6", "done after last write",
              32'({done, error}), 32'h2);
        check(mem_we == 1'b0, "R5", "65th write", 32'(mem_we), 0);
        @(negedge clk);
        check(done == 1'b0, "R6", "done length", 32'(done), 0);
        check(mem_we == 1'b0, "R8", "restart from ignored start", 32'(mem_we), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; switch_reg = '0; mem_size = 16'd1024;
        socket_present = 4'hF; salt = 16'h5A3C;
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0 && done == 1'b0 && error == 1'b0, "R1",
              "reset outputs", 32'({mem_we, done, error}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_we == 1'b0 && done == 1'b0, "R1", "idle after reset",
              32'({mem_we, done}), 0);

        // Directed: each socket, select-code extremes, size extremes.
        for (int s = 0; s < 4; s++)
            run_copy({2'(s), 2'b11, 6'(s * 21), 6'h2A}, 16'd8192, 4'hF, 1'b0);
        run_copy({2'd1, 2'b00, 6'h00, 6'h3F}, 16'd64, 4'hF, 1'b0);
        run_copy({2'd2, 2'b00, 6'h3F, 6'h00}, 16'd32768, 4'hF, 1'b0);
        run_copy({2'd3, 2'b10, 6'h15, 6'h11}, 16'd16384, 4'b0111, 1'b0);
        run_copy({2'd0, 2'b01, 6'h0C, 6'h05}, 16'd2048, 4'hF, 1'b1);

        // Random mix, including empty sockets and disturbances.
        for (int n = 0; n < 30; n++) begin
            salt = 16'($urandom);
            run_copy(16'($urandom), 16'(64 + ($urandom % 32705)),
                     4'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule